// File: doc/BRIEF.md
# Flash Self-Programming Command Sequencer

This block sits between a CPU and a flash controller and turns single register writes into flash operations. Software writes an 8-bit control register. The write sets the enable bit and at most one command bit. That arms a short window. Within the window, a store strobe from the CPU launches the armed operation as a one-cycle request to the flash controller. A load strobe can instead fetch lock or fuse bits. If no strobe arrives, the command lapses.

Page erase, page write and lock-bit set are timed operations. For these the enable bit stays set until the flash controller pulses done. A buffer load is armed by the enable bit alone and completes at once, as does a section re-enable. The block tracks a section-busy flag for the read-while-write section, which is the region below `RWW_LIMIT`. It aborts a partially filled page buffer when software writes the re-enable bit. It raises a ready interrupt whenever no command is pending.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0, `fl_req` and `fl_abort` are 0, and `irq` is 0.
- R2: `reg_rdata` bits are {7: irq enable, 6: section busy, 5: signature flag, 4: re-enable, 3: lock set, 2: page write, 1: page erase, 0: enable}. Bit 6 is read-only and is not changed by register writes. Writing with bit 0 clear stores bits 7 and 5 and clears bits 4..0.
- R3: A write with bit 0 set arms the command, and `STORE_WIN` (4) cycles follow in which a store strobe is accepted. In the cycle after an accepted strobe, `fl_req` is 1 for exactly one cycle. If no strobe arrives in those cycles, bits 4..0 read 0 from the next cycle on, and a later strobe issues no request.
- R4: An accepted strobe with erase (bit 1) issues `fl_op`=1, and one with page write (bit 2) issues `fl_op`=2. In both cases `fl_addr` and `fl_wdata` carry the strobe's address and data. Bit 0 and the command bit stay set until `fl_done`, then read 0. Section busy is set if the address is below `RWW_LIMIT` and left unchanged otherwise.
- R5: An accepted strobe with lock set (bit 3) issues `fl_op`=4 with `fl_addr`=0 and `fl_wdata`={8'h00, low data byte}. Bit 3 stays set until `fl_done` and then clears. It also clears when the window lapses unused.
- R6: During the first `LOAD_WIN` (3) cycles of an armed lock-set window, a load strobe drives `rd_override`=1 in the same cycle. `rd_byte` is `lock_bits` when address bit 0 is 1 and `fuse_bits` when it is 0. In the 4th cycle, or with no lock set armed, `rd_override` is 0.
- R7: An accepted strobe with re-enable (bit 4) issues `fl_op`=5 and clears section busy. While a timed operation is in progress, register writes change only bit 7, so section busy and the command bits are unchanged.
- R8: An accepted strobe with no command bit is a buffer load. It issues `fl_op`=3, clears section busy and bit 0, and marks a buffer load as under way.
- R9: A register write with bit 4 set while a buffer load is under way pulses `fl_abort` for one cycle on the next cycle and ends the load. A page write also ends it. Without a load under way, `fl_abort` stays 0.
- R10: `irq` = irq enable AND `gie` AND NOT enable bit.
- R11: A write with bit 0 set and more than one of bits 4..1 set arms nothing. Bits 4..0 read 0, and a following strobe issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| gie | input | 1 | CPU global interrupt flag |
| store_stb | input | 1 | Store-instruction strobe |
| load_stb | input | 1 | Load-instruction strobe |
| cpu_addr | input | ADDR_W | Address from the CPU pointer |
| cpu_wdata | input | 16 | Data word from the CPU |
| lock_bits | input | 8 | Current lock bits |
| fuse_bits | input | 8 | Current fuse bits |
| rd_override | output | 1 | Load returns `rd_byte` instead of memory |
| rd_byte | output | 8 | Lock or fuse byte for an overridden load |
| fl_req | output | 1 | One-cycle request to the flash controller |
| fl_op | output | 3 | Operation code: 1 erase, 2 write, 3 buffer load, 4 lock set, 5 re-enable |
| fl_addr | output | ADDR_W | Request address |
| fl_wdata | output | 16 | Request data |
| fl_done | input | 1 | Completion pulse for timed operations |
| fl_abort | output | 1 | Discard the page buffer contents |
| rww_busy | output | 1 | Read-while-write section blocked |
| irq | output | 1 | Ready interrupt |

## Verification
The bench builds the block with ADDR_W=16, STORE_WIN=4, LOAD_WIN=3 and RWW_LIMIT=16'h7000. With these values, random addresses land on both sides of the section boundary. The strobe windows are also short enough to hit both the last accepted cycle and the first lapsed cycle directly. Random buffer loads with random delays inside the window cover the request payload and the interrupt. Directed sequences cover timed operations, blocked writes, load aborts and multi-command writes.

// File: rtl/flash_selfprog_ctrl.sv
module flash_selfprog_ctrl #(
  parameter int ADDR_W = 16,
  parameter int STORE_WIN = 4,
  parameter int LOAD_WIN = 3,
  parameter logic [ADDR_W-1:0] RWW_LIMIT = ADDR_W'(16'h7000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              gie,
  input  logic              store_stb,
  input  logic              load_stb,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [15:0]       cpu_wdata,
  input  logic [7:0]        lock_bits,
  input  logic [7:0]        fuse_bits,
  output logic              rd_override,
  output logic [7:0]        rd_byte,
  output logic              fl_req,
  output logic [2:0]        fl_op,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [15:0]       fl_wdata,
  input  logic              fl_done,
  output logic              fl_abort,
  output logic              rww_busy,
  output logic              irq
);
  localparam int CW = $clog2(STORE_WIN + 1);
  localparam logic [CW-1:0] WIN = CW'(STORE_WIN);
  localparam logic [CW-1:0] LD_FLOOR = CW'(STORE_WIN - LOAD_WIN);
  localparam logic [2:0] OP_ERASE = 3'd1;
  localparam logic [2:0] OP_WRITE = 3'd2;
  localparam logic [2:0] OP_LOAD = 3'd3;
  localparam logic [2:0] OP_LOCK = 3'd4;
  localparam logic [2:0] OP_REEN = 3'd5;

  logic ie, sb, sig, rre, blb, wrt, ers, en;
  logic timed, load_act;
  logic [CW-1:0] cnt;

  logic [2:0] ncmd;
  assign ncmd = 3'(reg_wdata[4]) + 3'(reg_wdata[3]) + 3'(reg_wdata[2]) + 3'(reg_wdata[1]);

  logic armed, take, to_rww;
  assign armed = en & ~timed;
  assign take = armed & store_stb;
  assign to_rww = cpu_addr < RWW_LIMIT;

  assign rd_override = load_stb & armed & blb & (cnt > LD_FLOOR);
  assign rd_byte = cpu_addr[0] ? lock_bits : fuse_bits;
  assign irq = ie & gie & ~en;
  assign rww_busy = sb;
  assign reg_rdata = {ie, sb, sig, rre, blb, wrt, ers, en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ie, sb, sig, rre, blb, wrt, ers, en} <= '0;
      timed <= 1'b0;
      load_act <= 1'b0;
      cnt <= '0;
      fl_req <= 1'b0;
      fl_op <= '0;
      fl_addr <= '0;
      fl_wdata <= '0;
      fl_abort <= 1'b0;
    end else begin
      fl_req <= 1'b0;
      fl_abort <= 1'b0;
      if (reg_we && reg_wdata[4] && load_act) begin
        fl_abort <= 1'b1;
        load_act <= 1'b0;
      end
      if (timed) begin
        if (reg_we) ie <= reg_wdata[7];
        if (fl_done) begin
          timed <= 1'b0;
          {blb, wrt, ers, en} <= '0;
        end
      end else if (reg_we) begin
        ie <= reg_wdata[7];
        sig <= reg_wdata[5];
        if (reg_wdata[0] && ncmd <= 3'd1) begin
          {rre, blb, wrt, ers, en} <= reg_wdata[4:0];
          cnt <= WIN;
        end else begin
          {rre, blb, wrt, ers, en} <= '0;
          cnt <= '0;
        end
      end else if (take) begin
        fl_req <= 1'b1;
        fl_addr <= cpu_addr;
        fl_wdata <= cpu_wdata;
        cnt <= '0;
        if (ers || wrt) begin
          fl_op <= ers ? OP_ERASE : OP_WRITE;
          timed <= 1'b1;
          if (to_rww) sb <= 1'b1;
          if (wrt) load_act <= 1'b0;
        end else if (blb) begin
          fl_op <= OP_LOCK;
          fl_addr <= '0;
          fl_wdata <= {8'h00, cpu_wdata[7:0]};
          timed <= 1'b1;
        end else if (rre) begin
          fl_op <= OP_REEN;
          sb <= 1'b0;
          rre <= 1'b0;
          en <= 1'b0;
        end else begin
          fl_op <= OP_LOAD;
          sb <= 1'b0;
          load_act <= 1'b1;
          en <= 1'b0;
        end
      end else if (armed) begin
        if (cnt == CW'(1)) begin
          {rre, blb, wrt, ers, en} <= '0;
          cnt <= '0;
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
    end
  end

  assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req |=> !fl_req);
  assert_window_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cnt == CW'(1) && !store_stb && !reg_we) |=> !en);
  assert_rww_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && (fl_op == OP_ERASE || fl_op == OP_WRITE) && fl_addr < RWW_LIMIT) |-> rww_busy);
  assert_timed_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (timed && !fl_done) |=> en);
  assert_reen_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (timed && reg_we) |=> (rww_busy == $past(rww_busy)));
  assert_load_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && fl_op == OP_LOAD) |-> !rww_busy);
  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_wdata[4] && load_act) |=> fl_abort);
  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (reg_rdata[7] && !reg_rdata[0]));
  assert_multi_none_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !timed && reg_wdata[0] && ncmd > 3'd1) |=> (!en && !fl_req));
endmodule

// File: tb/test_flash_selfprog_ctrl.sv
module test_flash_selfprog_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic gie = 1'b0;
  logic store_stb = 1'b0;
  logic load_stb = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic [7:0] lock_bits = 8'h3C;
  logic [7:0] fuse_bits = 8'hD9;
  logic rd_override;
  logic [7:0] rd_byte;
  logic fl_req;
  logic [2:0] fl_op;
  logic [15:0] fl_addr;
  logic [15:0] fl_wdata;
  logic fl_done = 1'b0;
  logic fl_abort;
  logic rww_busy;
  logic irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  flash_selfprog_ctrl #(.ADDR_W(16), .STORE_WIN(4), .LOAD_WIN(3), .RWW_LIMIT(16'h7000)) i_flash_selfprog_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .gie(gie), .store_stb(store_stb), .load_stb(load_stb), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .lock_bits(lock_bits), .fuse_bits(fuse_bits),
    .rd_override(rd_override), .rd_byte(rd_byte), .fl_req(fl_req), .fl_op(fl_op),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_done(fl_done), .fl_abort(fl_abort),
    .rww_busy(rww_busy), .irq(irq));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic exp_irq(logic ie, logic g, logic en);
    return ie & g & ~en;
  endfunction

  function automatic logic exp_rww(logic [15:0] a);
    return a < 16'h7000;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    reg_we = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic stb(logic [15:0] a, logic [15:0] d);
    store_stb = 1'b1;
    cpu_addr = a;
    cpu_wdata = d;
    @(negedge clk);
    store_stb = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic done();
    fl_done = 1'b1;
    @(negedge clk);
    fl_done = 1'b0;
  endtask

  task automatic ld(logic [15:0] a, logic ov, logic [7:0] b, string tag);
    load_stb = 1'b1;
    cpu_addr = a;
    #1;
    chk({tag, " override"}, 32'(rd_override), 32'(ov));
    if (ov) chk({tag, " byte"}, 32'(rd_byte), 32'(b));
    @(negedge clk);
    load_stb = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    gie = 1'b1;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reg", 32'(reg_rdata), 0);
    chk("R1 req", 32'(fl_req), 0);
    chk("R1 abort", 32'(fl_abort), 0);
    chk("R1 irq", 32'(irq), 0);

    wr(8'hE0);
    chk("R2 busy read-only", 32'(reg_rdata), 32'hA0);
    chk("R10 irq on", 32'(irq), 32'(exp_irq(1, gie, 0)));
    gie = 1'b0;
    #1 chk("R10 irq gie off", 32'(irq), 0);
    gie = 1'b1;
    wr(8'h00);

    for (int i = 0; i < 24; i++) begin
      logic [15:0] a;
      logic [15:0] d;
      logic ie;
      int k;
      a = 16'($urandom);
      d = 16'($urandom);
      ie = 1'($urandom);
      k = int'($urandom % 4);
      wr({ie, 6'b0, 1'b1});
      chk("R10 irq armed", 32'(irq), 0);
      idle(k);
      stb(a, d);
      chk("R8 req", 32'(fl_req), 1);
      chk("R8 op", 32'(fl_op), 3);
      chk("R8 addr", 32'(fl_addr), 32'(a));
      chk("R8 data", 32'(fl_wdata), 32'(d));
      chk("R3 enable cleared", 32'(reg_rdata[0]), 0);
      chk("R10 irq after", 32'(irq), 32'(exp_irq(ie, gie, 0)));
      @(negedge clk);
      chk("R3 single pulse", 32'(fl_req), 0);
    end
    wr(8'h10);
    wr(8'h00);

    wr(8'h01);
    idle(3);
    stb(16'h0042, 16'h1111);
    chk("R3 last window cycle", 32'(fl_req), 1);
    wr(8'h01);
    idle(4);
    chk("R3 lapsed", 32'(reg_rdata[4:0]), 0);
    stb(16'h0042, 16'h1111);
    chk("R3 no req after lapse", 32'(fl_req), 0);

    wr(8'h03);
    stb(16'h0100, 16'h0);
    chk("R4 erase op", 32'(fl_op), 1);
    chk("R4 erase req", 32'(fl_req), 1);
    chk("R4 busy set", 32'(rww_busy), 32'(exp_rww(16'h0100)));
    idle(6);
    chk("R4 held", 32'(reg_rdata[1:0]), 3);
    wr(8'h11);
    chk("R7 blocked write", 32'(reg_rdata), 32'h43);
    chk("R7 busy kept", 32'(rww_busy), 1);
    done();
    chk("R4 done clears", 32'(reg_rdata[4:0]), 0);
    chk("R4 busy after done", 32'(rww_busy), 1);
    wr(8'h11);
    stb(16'h0, 16'h0);
    chk("R7 op", 32'(fl_op), 5);
    chk("R7 busy cleared", 32'(rww_busy), 0);
    chk("R7 bits cleared", 32'(reg_rdata[4:0]), 0);

    wr(8'h05);
    stb(16'h8000, 16'h5A5A);
    chk("R4 write op", 32'(fl_op), 2);
    chk("R4 upper section no busy", 32'(rww_busy), 0);
    done();
    wr(8'h05);
    stb(16'h0200, 16'h0);
    chk("R4 write busy", 32'(rww_busy), 1);
    done();
    wr(8'h01);
    stb(16'h0300, 16'h7777);
    chk("R8 load clears busy", 32'(rww_busy), 0);

    wr(8'h10);
    chk("R9 abort pulse", 32'(fl_abort), 1);
    @(negedge clk);
    chk("R9 abort one cycle", 32'(fl_abort), 0);
    wr(8'h10);
    chk("R9 no abort idle", 32'(fl_abort), 0);
    wr(8'h01);
    stb(16'h0300, 16'h1);
    wr(8'h05);
    stb(16'h8000, 16'h0);
    done();
    wr(8'h10);
    chk("R9 write ends load", 32'(fl_abort), 0);

    wr(8'h09);
    chk("R5 armed", 32'(reg_rdata[3]), 1);
    stb(16'h1234, 16'hABCD);
    chk("R5 op", 32'(fl_op), 4);
    chk("R5 addr", 32'(fl_addr), 0);
    chk("R5 data", 32'(fl_wdata), 32'h00CD);
    chk("R5 held", 32'(reg_rdata[3]), 1);
    done();
    chk("R5 done clears", 32'(reg_rdata[3]), 0);
    wr(8'h09);
    idle(4);
    chk("R5 lapse clears", 32'(reg_rdata[3]), 0);

    wr(8'h09);
    ld(16'h0001, 1, 8'h3C, "R6 c1 lock");
    ld(16'h0000, 1, 8'hD9, "R6 c2 fuse");
    ld(16'h0003, 1, 8'h3C, "R6 c3 lock");
    ld(16'h0001, 0, 8'h00, "R6 c4 closed");
    wr(8'h01);
    ld(16'h0001, 0, 8'h00, "R6 no lock armed");
    idle(4);

    wr(8'h07);
    chk("R11 nothing armed", 32'(reg_rdata[4:0]), 0);
    stb(16'h0100, 16'h0);
    chk("R11 no req", 32'(fl_req), 0);
    wr(8'h19);
    chk("R11 nothing armed 2", 32'(reg_rdata[4:0]), 0);
    stb(16'h0100, 16'h0);
    chk("R11 no req 2", 32'(fl_req), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule